// File: doc/BRIEF.md
# Data-Register Jump Condition Evaluator

This block decides whether a conditional jump on a 60-bit data register is taken. An operand word and a 3-bit test selector are presented together with a one-cycle strobe. One clock later the block raises a one-cycle completion pulse and presents the branch decision. The decision stays on the output until the next strobe.

Operands are one's-complement words. Two of the selectable tests look at the word as an integer: zero/nonzero and sign. The other two treat it as a floating-point value. In that layout the sign is bit 59, the 11-bit biased exponent is bits 58..48 and the coefficient is bits 47..0. These tests compare the exponent with the two reserved codes, one for infinite and one for indefinite. For negative words the exponent field is complemented before the comparison.

Computing the jump target and fetching the next instruction are handled elsewhere.

Top module: `jc_eval`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `res_done` and `res_take` are 0.
- R2: `res_done` is 1 in exactly the cycle after each clock edge where `op_valid` was 1, and 0 otherwise. Back-to-back strobes give back-to-back pulses.
- R3: `res_take` changes only one cycle after a strobe. Without a strobe it holds its value, whatever `op_word` and `op_sel` do.
- R4: Selector 0 (zero test) is taken when the word is all zeros or all ones (negative zero). For any other word it is not taken.
- R5: Selector 1 (nonzero test) is taken exactly when selector 0 would not be taken.
- R6: Selector 2 (positive) is taken when bit 59 is 0. Selector 3 (negative) is taken when bit 59 is 1, so negative zero counts as negative.
- R7: The effective exponent is bits 58..48 when bit 59 is 0, and the bitwise complement of those bits when bit 59 is 1.
- R8: Selector 5 (out of range) is taken when the effective exponent equals octal 3777 (all ones). Selector 4 (in range) is taken otherwise.
- R9: Selector 7 (indefinite) is taken when the effective exponent equals octal 1777 (top bit 0, rest ones). Selector 6 (definite) is taken otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Strobe: operand and selector are valid this cycle |
| op_word | input | 60 | One's-complement data register value |
| op_sel | input | 3 | Test selector, 0..7 |
| res_done | output | 1 | One-cycle pulse, one clock after the strobe |
| res_take | output | 1 | Branch decision, updated with each pulse |

## Verification
A wrong internal state shows up on `res_take` in the cycle right after the strobe. For example, a missing sign complement of the exponent flips the range and definite results for negative operands only. A zero detector blind to all-ones flips selectors 0 and 1 for negative zero. A mixed-up pairing in the selector mux inverts every odd or even test. A faulty hold or strobe register shows up as `res_take` drifting between strobes, or as `res_done` missing or lasting too long. Either of these is visible within one cycle of the offending input change.

// File: rtl/jc_pkg.sv
package jc_pkg;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned TEST_N = 1 << SEL_W;
  localparam int unsigned BASE_N = TEST_N / 2;

  // Even codes are the base tests; odd codes are their inverses.
  typedef enum logic [SEL_W-1:0] {
    JT_ZERO   = 3'd0,
    JT_NZERO  = 3'd1,
    JT_POS    = 3'd2,
    JT_NEG    = 3'd3,
    JT_INRNG  = 3'd4,
    JT_OUTRNG = 3'd5,
    JT_DEF    = 3'd6,
    JT_INDEF  = 3'd7
  } jt_sel_e;

  typedef struct packed {
    logic is_zero;  // +0 or -0
    logic sign;
    logic exp_inf;  // effective exponent is the infinite code
    logic exp_ind;  // effective exponent is the indefinite code
  } jt_flags_t;
endpackage

// File: rtl/jc_field_decode.sv
module jc_field_decode #(
  parameter int unsigned WORD_W = 60,
  parameter int unsigned EXP_W  = 11
) (
  input  logic [WORD_W-1:0]     word,
  output jc_pkg::jt_flags_t     flags
);
  localparam int unsigned SIGN_B  = WORD_W - 1;
  localparam int unsigned EXP_LSB = WORD_W - 1 - EXP_W;
  localparam logic [EXP_W-1:0] EXP_INF = {EXP_W{1'b1}};
  localparam logic [EXP_W-1:0] EXP_IND = {1'b0, {(EXP_W-1){1'b1}}};

  logic [EXP_W-1:0] exp_raw;
  logic [EXP_W-1:0] exp_eff;

  always_comb begin
    exp_raw       = word[SIGN_B-1:EXP_LSB];
    exp_eff       = word[SIGN_B] ? ~exp_raw : exp_raw;
    flags.sign    = word[SIGN_B];
    flags.is_zero = (~|word) | (&word);
    flags.exp_inf = (exp_eff == EXP_INF);
    flags.exp_ind = (exp_eff == EXP_IND);
  end
endmodule

// File: rtl/jc_cond_select.sv
module jc_cond_select
  import jc_pkg::*;
(
  input  jt_flags_t          flags,
  input  logic [SEL_W-1:0]   sel,
  output logic               take
);
  logic [BASE_N-1:0] base;
  logic [TEST_N-1:0] tests;

  always_comb begin
    base[0] = flags.is_zero;
    base[1] = ~flags.sign;
    base[2] = ~flags.exp_inf;
    base[3] = ~flags.exp_ind;
  end

  for (genvar k = 0; k < BASE_N; k++) begin : g_pair
    assign tests[2*k]   = base[k];
    assign tests[2*k+1] = ~base[k];
  end

  assign take = tests[sel];
endmodule

// File: rtl/jc_eval.sv
module jc_eval #(
  parameter int unsigned WORD_W = 60,
  parameter int unsigned EXP_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [WORD_W-1:0] op_word,
  input  logic [2:0]        op_sel,
  output logic              res_done,
  output logic              res_take
);
  jc_pkg::jt_flags_t flags;
  logic              take_c;

  jc_field_decode #(.WORD_W(WORD_W), .EXP_W(EXP_W)) u_dec (
    .word  (op_word),
    .flags (flags)
  );

  jc_cond_select u_sel (
    .flags (flags),
    .sel   (op_sel),
    .take  (take_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_done <= 1'b0;
      res_take <= 1'b0;
    end else begin
      res_done <= op_valid;
      if (op_valid) res_take <= take_c;
    end
  end
endmodule

// File: rtl/jc_eval_chk.sv
module jc_eval_chk #(
  parameter int unsigned WORD_W = 60,
  parameter int unsigned EXP_W  = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [WORD_W-1:0] op_word,
  input logic [2:0]        op_sel,
  input logic              res_done,
  input logic              res_take
);
  localparam int unsigned EXP_LSB = WORD_W - 1 - EXP_W;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!res_done && !res_take));

  a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> res_done);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !res_done);

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(res_take));

  a_r4_zero_both: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 3'd0 && (op_word == '0 || op_word == '1)) |=> res_take);

  a_r6_sign: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 3'd3) |=> (res_take == $past(op_word[WORD_W-1])));

  a_r8_pos_inf: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 3'd5 && !op_word[WORD_W-1]
     && (&op_word[WORD_W-2:EXP_LSB])) |=> res_take);

  a_r7_neg_inf: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 3'd5 && op_word[WORD_W-1]
     && (~|op_word[WORD_W-2:EXP_LSB])) |=> res_take);
endmodule

bind jc_eval jc_eval_chk #(.WORD_W(WORD_W), .EXP_W(EXP_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_valid (op_valid),
  .op_word  (op_word),
  .op_sel   (op_sel),
  .res_done (res_done),
  .res_take (res_take)
);

// File: tb/sim_jc_eval.sv
module sim_jc_eval;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [59:0] op_word = '0;
  logic [2:0]  op_sel = '0;
  logic        res_done;
  logic        res_take;
  int          n_chk = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  jc_eval u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_word(op_word),
    .op_sel(op_sel), .res_done(res_done), .res_take(res_take)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // strobe one operand, sample at the following negedge
  task automatic run_one(input logic [59:0] w, input logic [2:0] s,
                         input logic exp, input string tag);
    @(negedge clk);
    op_valid = 1'b1; op_word = w; op_sel = s;
    @(negedge clk);
    op_valid = 1'b0;
    check({tag, " done (R2)"}, res_done, 1'b1);
    check(tag, res_take, exp);
  endtask

  function automatic logic [59:0] fp(input logic sg, input logic [10:0] e);
    return {sg, e, 48'h0000_1234_5678};
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 done", res_done, 1'b0);
    check("R1 take", res_take, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 done after release", res_done, 1'b0);
  endtask

  task automatic t_zero();
    run_one('0, 3'd0, 1'b1, "R4 +0");
    run_one('1, 3'd0, 1'b1, "R4 -0");
    run_one(60'd1, 3'd0, 1'b0, "R4 one");
    run_one('0, 3'd1, 1'b0, "R5 +0");
    run_one('1, 3'd1, 1'b0, "R5 -0");
    run_one(60'h800_0000_0000_0000, 3'd1, 1'b1, "R5 sign only");
  endtask

  task automatic t_sign();
    run_one(60'd77, 3'd2, 1'b1, "R6 pos on positive");
    run_one(~60'd77, 3'd2, 1'b0, "R6 pos on negative");
    run_one(~60'd77, 3'd3, 1'b1, "R6 neg on negative");
    run_one('1, 3'd3, 1'b1, "R6 neg on -0");
    run_one('0, 3'd3, 1'b0, "R6 neg on +0");
  endtask

  task automatic t_range();
    run_one(fp(1'b0, 11'h7FF), 3'd5, 1'b1, "R8 +inf out");
    run_one(fp(1'b0, 11'h7FF), 3'd4, 1'b0, "R8 +inf in");
    run_one(fp(1'b0, 11'h400), 3'd4, 1'b1, "R8 normal in");
    run_one(fp(1'b1, 11'h000), 3'd5, 1'b1, "R7 -inf out");
    run_one(fp(1'b1, 11'h7FF), 3'd5, 1'b0, "R7 neg raw ones");
    run_one(fp(1'b0, 11'h000), 3'd4, 1'b1, "R7 pos raw zero");
  endtask

  task automatic t_indef();
    run_one(fp(1'b0, 11'h3FF), 3'd7, 1'b1, "R9 +ind");
    run_one(fp(1'b0, 11'h3FF), 3'd6, 1'b0, "R9 +ind def");
    run_one(fp(1'b1, 11'h400), 3'd7, 1'b1, "R7 -ind");
    run_one(fp(1'b0, 11'h400), 3'd7, 1'b0, "R9 pos 2000 oct");
    run_one(fp(1'b1, 11'h3FF), 3'd6, 1'b1, "R7 neg raw 1777");
  endtask

  task automatic t_hold();
    run_one('0, 3'd0, 1'b1, "R3 setup");
    op_word = 60'd5; op_sel = 3'd0;
    repeat (3) begin
      @(negedge clk);
      check("R3 take held", res_take, 1'b1);
      check("R2 no pulse", res_done, 1'b0);
    end
  endtask

  task automatic t_b2b();
    @(negedge clk);
    op_valid = 1'b1; op_word = '0; op_sel = 3'd1;
    @(negedge clk);
    check("R2 b2b first", res_done, 1'b1);
    check("R5 b2b first", res_take, 1'b0);
    op_word = 60'd3;
    @(negedge clk);
    op_valid = 1'b0;
    check("R2 b2b second", res_done, 1'b1);
    check("R5 b2b second", res_take, 1'b1);
    @(negedge clk);
    check("R2 b2b end", res_done, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_zero();
    t_sign();
    t_range();
    t_indef();
    t_hold();
    t_b2b();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule